// File: doc/BRIEF.md
# Machine Clock Enable Generator with Multiplier and Low-Power Modes

This block turns a reference clock into the machine-cycle enable that paces a small processor core and its timers. The reference clock runs at a fixed multiple `FPX` of the crystal rate. It stands in for the fastest multiplied clock, so the 2X and 4X settings, the plain divide-by-4 setting and a slow low-power setting all become enable patterns on one clock. No clock is switched, so no clock glitch can occur.

Software selects a mode through a write strobe with a set of configuration fields. A mode request takes effect only at the end of the machine cycle in progress. A request for a multiplier setting that would push the internal clock above the ceiling for the reported crystal frequency is recorded as divide-by-4. While the block is in the low-power setting, an enabled switchback returns it at once to divide-by-4 when an external interrupt or a serial start bit arrives. The block also derives a serial shift enable and an address-latch enable from the machine cycle. It holds the core in reset for a fixed number of crystal clocks after power-on.

Top module: `mclk_gen`

## Requirements
- R1: After `rst_n` is released, `core_hold` stays high for exactly `POR_XTAL*FPX` reference cycles and then never rises again. While it is high, `mc_en`, `ser0_en` and `ale_en` stay low.
- R2: Mode code 0 (divide-by-4) gives one `mc_en` pulse every `NORM_DIV*FPX` reference cycles, which is 16 with the defaults. This is also the mode after reset.
- R3: Mode code 1 (2X) gives one `mc_en` pulse every `NORM_DIV*FPX/2` reference cycles, which is 8 with the defaults.
- R4: Mode code 2 (4X) gives one `mc_en` pulse every `NORM_DIV*FPX/4` reference cycles, which is 4 with the defaults. `mc_en` is never high in two consecutive cycles.
- R5: Mode code 3 (low power) gives one `mc_en` pulse every `PMM_DIV*FPX` reference cycles, which is 4096 with the defaults.
- R6: A written request for code 2 is recorded as code 0 when `xtal_khz` exceeds `CEIL_KHZ/4`. A written request for code 1 is recorded as code 0 when `xtal_khz` exceeds `CEIL_KHZ/2`.
- R7: A mode write leaves the machine cycle in progress and `mode_now` unchanged. The new mode is applied in the cycle after the next `mc_en` pulse, and the interval that follows has the new length.
- R8: When switchback is enabled and the block is in mode 3, a high `ext_irq` or `ser_start` sets `mode_now` to 0 in the next cycle. The next `mc_en` then comes `NORM_DIV*FPX` cycles after the cycle in which the input was high.
- R9: With switchback disabled, or in any mode other than 3, `ext_irq` and `ser_start` change neither `mode_now` nor the `mc_en` spacing.
- R10: With `sm2` = 1, `ser0_en` pulses together with every `mc_en`. With `sm2` = 0, it pulses together with every third `mc_en`, starting with the first after reset.
- R11: With `ale_off` = 0, `ale_en` pulses together with every `mc_en`. With `ale_off` = 1, `ale_en` stays low.
- R12: `mode_now` reports the mode code in effect, using the codes given in R2 to R5, and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at FPX times the crystal rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for all configuration fields |
| cfg_mode | input | 2 | Requested mode code (0 div4, 1 2X, 2 4X, 3 low power) |
| cfg_swb_en | input | 1 | Switchback enable |
| cfg_sm2 | input | 1 | Serial shift rate select (1 = every machine cycle) |
| cfg_ale_off | input | 1 | Suppress address-latch enable pulses |
| xtal_khz | input | 16 | Crystal frequency in kHz used for the multiplier limit |
| ext_irq | input | 1 | External interrupt wake event |
| ser_start | input | 1 | Serial start-bit wake event |
| core_hold | output | 1 | Power-on reset hold to the core |
| mc_en | output | 1 | Machine-cycle enable pulse |
| ser0_en | output | 1 | Serial synchronous-mode shift enable |
| ale_en | output | 1 | Address-latch enable pulse |
| mode_now | output | 2 | Mode code in effect |

## Verification
The assertions assume that `xtal_khz` is stable around a mode write. They also assume that no write arrives while `core_hold` is high, and that the wake inputs are ordinary synchronous levels. The bench sets `xtal_khz` only when `cfg_wr` is low and issues its first write after the hold ends. It drives every input at the falling edge, so the enable spacing seen at the ports depends only on the selected mode and on the wake pulses.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  typedef enum logic [1:0] {
    M_DIV4 = 2'd0,
    M_X2   = 2'd1,
    M_X4   = 2'd2,
    M_PMM  = 2'd3
  } mode_t;
endpackage

// File: rtl/mclk_por.sv
module mclk_por #(
  parameter int unsigned FPX      = 4,
  parameter int unsigned POR_XTAL = 65536
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold
);
  localparam int unsigned LIMIT = POR_XTAL * FPX;
  localparam int unsigned PW    = $clog2(LIMIT + 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != PW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hold = (cnt != PW'(LIMIT));

  AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> !hold); // R1
endmodule

// File: rtl/mclk_mode_ctl.sv
module mclk_mode_ctl import mclk_pkg::*; #(
  parameter int unsigned KHZ_W    = 16,
  parameter int unsigned CEIL_KHZ = 40000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_swb_en,
  input  logic             cfg_sm2,
  input  logic             cfg_ale_off,
  input  logic [KHZ_W-1:0] xtal_khz,
  input  logic             ext_irq,
  input  logic             ser_start,
  input  logic             fire,
  output mode_t            act_mode,
  output mode_t            load_mode,
  output logic             restart,
  output logic             sm2_q,
  output logic             ale_off_q
);
  localparam int unsigned X2_MAX = CEIL_KHZ / 2;
  localparam int unsigned X4_MAX = CEIL_KHZ / 4;

  mode_t pend_mode;
  mode_t req_ok;
  logic  swb_q;

  always_comb begin
    case (mode_t'(cfg_mode))
      M_X2:    req_ok = (32'(xtal_khz) <= X2_MAX) ? M_X2 : M_DIV4;
      M_X4:    req_ok = (32'(xtal_khz) <= X4_MAX) ? M_X4 : M_DIV4;
      M_PMM:   req_ok = M_PMM;
      default: req_ok = M_DIV4;
    endcase
  end

  assign restart   = swb_q && (act_mode == M_PMM) && (ext_irq || ser_start);
  assign load_mode = restart ? M_DIV4 : pend_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode  <= M_DIV4;
      pend_mode <= M_DIV4;
      swb_q     <= 1'b0;
      sm2_q     <= 1'b0;
      ale_off_q <= 1'b0;
    end else begin
      if (restart) begin
        act_mode  <= M_DIV4;
        pend_mode <= M_DIV4;
      end else begin
        if (fire)   act_mode  <= pend_mode;
        if (cfg_wr) pend_mode <= req_ok;
      end
      if (cfg_wr) begin
        swb_q     <= cfg_swb_en;
        sm2_q     <= cfg_sm2;
        ale_off_q <= cfg_ale_off;
      end
    end
  end

  AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> $past(fire || restart)); // R7
  AST_X4_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !restart && cfg_mode == 2'd2 && 32'(xtal_khz) > X4_MAX) |=> pend_mode == M_DIV4); // R6
  AST_X2_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !restart && cfg_mode == 2'd1 && 32'(xtal_khz) > X2_MAX) |=> pend_mode == M_DIV4); // R6
  AST_SWB_DIV4: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_q && act_mode == M_PMM && ext_irq) |=> act_mode == M_DIV4); // R8
endmodule

// File: rtl/mclk_divider.sv
module mclk_divider import mclk_pkg::*; #(
  parameter int unsigned FPX      = 4,
  parameter int unsigned NORM_DIV = 4,
  parameter int unsigned PMM_DIV  = 1024
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  restart,
  input  mode_t load_mode,
  output logic  fire
);
  localparam int unsigned P_DIV4 = NORM_DIV * FPX;
  localparam int unsigned P_X2   = P_DIV4 / 2;
  localparam int unsigned P_X4   = P_DIV4 / 4;
  localparam int unsigned P_PMM  = PMM_DIV * FPX;
  localparam int unsigned CW     = $clog2(P_PMM);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] reload(input mode_t m);
    case (m)
      M_X2:    return CW'(P_X2 - 1);
      M_X4:    return CW'(P_X4 - 1);
      M_PMM:   return CW'(P_PMM - 1);
      default: return CW'(P_DIV4 - 1);
    endcase
  endfunction

  assign fire = (cnt == '0) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= reload(M_DIV4);
    end else if (restart) begin
      cnt <= reload(load_mode);
    end else if (!hold) begin
      cnt <= (cnt == '0) ? reload(load_mode) : cnt - 1'b1;
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R4
endmodule

// File: rtl/mclk_ser_ale.sv
module mclk_ser_ale (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic sm2,
  input  logic ale_off,
  output logic ser0_en,
  output logic ale_en
);
  logic [1:0] third;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      third <= 2'd0;
    end else if (mc_en) begin
      third <= (third == 2'd2) ? 2'd0 : third + 2'd1;
    end
  end

  assign ser0_en = mc_en && (sm2 || third == 2'd0);
  assign ale_en  = mc_en && !ale_off;

  AST_SER_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (!sm2 && ser0_en) |=> !ser0_en); // R10
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen import mclk_pkg::*; #(
  parameter int unsigned FPX      = 4,
  parameter int unsigned NORM_DIV = 4,
  parameter int unsigned PMM_DIV  = 1024,
  parameter int unsigned POR_XTAL = 65536,
  parameter int unsigned CEIL_KHZ = 40000,
  parameter int unsigned KHZ_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_swb_en,
  input  logic             cfg_sm2,
  input  logic             cfg_ale_off,
  input  logic [KHZ_W-1:0] xtal_khz,
  input  logic             ext_irq,
  input  logic             ser_start,
  output logic             core_hold,
  output logic             mc_en,
  output logic             ser0_en,
  output logic             ale_en,
  output logic [1:0]       mode_now
);
  mode_t act_mode;
  mode_t load_mode;
  logic  restart;
  logic  sm2_q;
  logic  ale_off_q;
  logic  fire;

  mclk_por #(.FPX(FPX), .POR_XTAL(POR_XTAL)) u_por (
    .clk(clk), .rst_n(rst_n), .hold(core_hold)
  );

  mclk_mode_ctl #(.KHZ_W(KHZ_W), .CEIL_KHZ(CEIL_KHZ)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_swb_en(cfg_swb_en), .cfg_sm2(cfg_sm2), .cfg_ale_off(cfg_ale_off),
    .xtal_khz(xtal_khz), .ext_irq(ext_irq), .ser_start(ser_start),
    .fire(fire), .act_mode(act_mode), .load_mode(load_mode),
    .restart(restart), .sm2_q(sm2_q), .ale_off_q(ale_off_q)
  );

  mclk_divider #(.FPX(FPX), .NORM_DIV(NORM_DIV), .PMM_DIV(PMM_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(core_hold), .restart(restart),
    .load_mode(load_mode), .fire(fire)
  );

  mclk_ser_ale u_sa (
    .clk(clk), .rst_n(rst_n), .mc_en(fire), .sm2(sm2_q),
    .ale_off(ale_off_q), .ser0_en(ser0_en), .ale_en(ale_en)
  );

  assign mc_en    = fire;
  assign mode_now = act_mode;

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold |-> !(mc_en || ser0_en || ale_en)); // R1
endmodule

// File: tb/mclk_gen_test.sv
module mclk_gen_test;
  localparam int unsigned POR = 16;
  localparam int unsigned FPX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_swb_en = 1'b0, cfg_sm2 = 1'b0, cfg_ale_off = 1'b0;
  logic [15:0] xtal_khz = 16'd8000;
  logic ext_irq = 1'b0, ser_start = 1'b0;
  logic core_hold, mc_en, ser0_en, ale_en;
  logic [1:0] mode_now;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mclk_gen #(.FPX(FPX), .POR_XTAL(POR)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_swb_en(cfg_swb_en), .cfg_sm2(cfg_sm2), .cfg_ale_off(cfg_ale_off),
    .xtal_khz(xtal_khz), .ext_irq(ext_irq), .ser_start(ser_start),
    .core_hold(core_hold), .mc_en(mc_en), .ser0_en(ser0_en),
    .ale_en(ale_en), .mode_now(mode_now)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] m, input bit swb, input bit sm2, input bit aoff);
    @(negedge clk);
    cfg_mode = m; cfg_swb_en = swb; cfg_sm2 = sm2; cfg_ale_off = aoff; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic next_mc(output int c);
    do @(negedge clk); while (!mc_en);
    c = cyc;
  endtask

  // Apply a mode, wait for it to take hold, then measure one interval.
  task automatic t_period(input logic [1:0] m, input int exp_code, input int exp_len, input string req);
    int t0, t1;
    wr(m, 0, 1, 0);
    next_mc(t0);
    @(negedge clk);
    chk(mode_now == exp_code, req, mode_now, exp_code);
    next_mc(t0);
    next_mc(t1);
    chk(t1 - t0 == exp_len, req, t1 - t0, exp_len);
  endtask

  task automatic t_reset();
    int n = 0;
    bit quiet = 1;
    @(negedge clk);
    rst_n = 1'b1;
    chk(mode_now == 0, "R12", mode_now, 0);
    while (core_hold && n < 1000) begin
      if (mc_en || ser0_en || ale_en) quiet = 0;
      n++;
      @(negedge clk);
    end
    chk(n == POR * FPX, "R1", n, POR * FPX);
    chk(quiet, "R1", quiet, 1);
  endtask

  task automatic t_div4_default();
    int t0, t1;
    next_mc(t0);
    next_mc(t1);
    chk(t1 - t0 == 16, "R2", t1 - t0, 16);
    chk(!core_hold, "R1", core_hold, 0);
  endtask

  task automatic t_boundary();
    int t0, t1, t2;
    wr(2'd0, 0, 1, 0);
    next_mc(t0); next_mc(t0);
    repeat (3) @(negedge clk);
    cfg_mode = 2'd2; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(mode_now == 0, "R7", mode_now, 0);
    next_mc(t1);
    chk(t1 - t0 == 16, "R7", t1 - t0, 16);
    @(negedge clk);
    chk(mode_now == 2, "R7", mode_now, 2);
    next_mc(t2);
    chk(t2 - t1 == 4, "R7", t2 - t1, 4);
  endtask

  task automatic t_limits();
    xtal_khz = 16'd15000;
    t_period(2'd2, 0, 16, "R6");
    t_period(2'd1, 1, 8, "R6");
    xtal_khz = 16'd25000;
    t_period(2'd1, 0, 16, "R6");
    xtal_khz = 16'd8000;
  endtask

  task automatic t_switchback(input bit use_irq);
    int t0, ce, t1;
    wr(2'd3, 1, 1, 0);
    next_mc(t0); next_mc(t0);
    chk(mode_now == 3, "R5", mode_now, 3);
    repeat (100) @(negedge clk);
    if (use_irq) ext_irq = 1'b1; else ser_start = 1'b1;
    ce = cyc;
    @(negedge clk);
    ext_irq = 1'b0; ser_start = 1'b0;
    chk(mode_now == 0, "R8", mode_now, 0);
    next_mc(t1);
    chk(t1 - ce == 16, "R8", t1 - ce, 16);
  endtask

  task automatic t_ignore();
    int t0, t1;
    wr(2'd3, 0, 1, 0);
    next_mc(t0);
    repeat (50) @(negedge clk);
    ext_irq = 1'b1; ser_start = 1'b1;
    @(negedge clk);
    ext_irq = 1'b0; ser_start = 1'b0;
    @(negedge clk);
    chk(mode_now == 3, "R9", mode_now, 3);
    next_mc(t1);
    chk(t1 - t0 == 4096, "R9", t1 - t0, 4096);
    wr(2'd0, 1, 1, 0);
    next_mc(t0); next_mc(t0);
    repeat (5) @(negedge clk);
    ext_irq = 1'b1;
    @(negedge clk);
    ext_irq = 1'b0;
    next_mc(t1);
    chk(t1 - t0 == 16, "R9", t1 - t0, 16);
    chk(mode_now == 0, "R9", mode_now, 0);
  endtask

  task automatic t_serial_ale();
    int t, n_ser, n_ale, n_mc, first, last;
    wr(2'd2, 0, 1, 0);
    next_mc(t); next_mc(t);
    n_ser = 0; n_ale = 0;
    for (int i = 0; i < 6; i++) begin
      next_mc(t);
      if (ser0_en) n_ser++;
      if (ale_en) n_ale++;
    end
    chk(n_ser == 6, "R10", n_ser, 6);
    chk(n_ale == 6, "R11", n_ale, 6);
    wr(2'd2, 0, 0, 1);
    next_mc(t);
    n_ser = 0; n_ale = 0; n_mc = 0; first = -1; last = -1;
    while (n_mc < 12) begin
      @(negedge clk);
      if (ale_en) n_ale++;
      if (ser0_en) begin
        n_ser++;
        if (first < 0) first = cyc;
        last = cyc;
      end
      if (mc_en) n_mc++;
    end
    chk(n_ser == 4, "R10", n_ser, 4);
    chk(last - first == 36, "R10", last - first, 36);
    chk(n_ale == 0, "R11", n_ale, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_div4_default();
    t_period(2'd1, 1, 8, "R3");
    t_period(2'd2, 2, 4, "R4");
    t_period(2'd0, 0, 16, "R2");
    t_boundary();
    t_limits();
    t_period(2'd3, 3, 4096, "R5");
    t_switchback(1);
    t_switchback(0);
    t_ignore();
    t_serial_ale();
    report();
  end
endmodule